// File: doc/BRIEF.md
# Multi-Channel Thermal Sample Controller

This block sequences a temperature-sensing converter over one internal channel and up to sixteen external channels. Software programs two control words through a simple write port. The first control word holds the run, reset, enable, bypass, sample-spacing, source-mode and external-index fields. The second holds the averaging depth. The block waits a settling latency after every start or reprogram. It then requests samples from the converter with a request/ready handshake and averages each set of 2^N returned samples. It publishes the mean and a validity flag in a status word.

A change of source is handled as stop, reprogram and restart. Any partial average is dropped and the validity flag stays low until a complete new set has been taken from the new source. The internal sensor is chosen implicitly whenever the mode field does not hold the external code. In that case the index field has no effect on the converter select lines.

Top module: `thermal_sample_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released with no writes, status_o reads zero and cvt_req_o is low.
- R2: Control word 0 (reg_sel=0) holds the source mode in bits 31:30 and the external index in bits 16:13. Mode value 2 drives cvt_ext_o=1 and cvt_sel_o equal to the index. Any other mode drives cvt_ext_o=0 and cvt_sel_o=0, whatever the index holds.
- R3: The running condition is start bit 0 set, enable bit 2 set and reset bit 1 clear. After a write that starts the block or reprograms the source, cvt_req_o stays low for LAT_CYC cycles and rises within two more. The validity flag stays low until the first full set is done.
- R4: status_o bits 9:0 hold floor(sum/2^N) of the last completed set of 2^N accepted samples. N is control word 1 (reg_sel=1) bits 2:0, taken at the first sample of each set. Bit 10 is the validity flag and bits 31:11 read zero.
- R5: With the bypass bit 6 of control word 0 set, every accepted sample is published on its own (N treated as 0).
- R6: The sample-spacing field in bits 25:24 (value s) sets the distance between request rises to (GAP_BASE<<s)+1 cycles when the converter answers on the first request cycle.
- R7: A write that changes the effective source (external flag or selected index) drops the validity flag from the next cycle. Any partial sum is discarded and the settling wait is restarted.
- R8: A write with start clear drops the validity flag from the next cycle and stops all requests. The last published sample is kept. Setting start again restarts with the full settling wait.
- R9: A write with enable clear or reset set stops requests and drops validity from the next cycle. It forces the sample field to zero one cycle later.
- R10: Once raised, cvt_req_o stays high with cvt_ext_o and cvt_sel_o stable until cvt_rdy_i is seen, unless a control write intervenes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control write strobe |
| reg_sel | input | 1 | Selects control word 0 (0) or control word 1 (1) |
| reg_wdata | input | 32 | Control write data |
| cvt_req_o | output | 1 | Sample request to the converter |
| cvt_ext_o | output | 1 | Converter source is external |
| cvt_sel_o | output | 4 | External sensor index for the converter |
| cvt_rdy_i | input | 1 | Converter sample ready; sample taken while request is high |
| cvt_data_i | input | SMP_W | Converter sample value |
| status_o | output | 32 | {zeros, valid, averaged sample} |

## Verification
The bench switches sources while a set is half collected. A design that keeps the partial sum would publish a mean that blends old and new sources, and the scoreboard would reject it. It writes a nonzero index while internal mode is selected, which catches a select decode that ignores the mode. It checks the request-free settling window after both a cold start and a source switch. An off-by-one counter would move the first request outside the expected cycle. It also stops, disables and holds the block in reset, which exposes a flag that lingers, a sample that is not zeroed, or requests issued while halted.

// File: rtl/thsc_pkg.sv
package thsc_pkg;
  localparam int B_START  = 0;
  localparam int B_RST    = 1;
  localparam int B_EN     = 2;
  localparam int B_BYP    = 6;
  localparam int CH_LO    = 13;
  localparam int CH_W     = 4;
  localparam int OSR_LO   = 24;
  localparam int OSR_W    = 2;
  localparam int MODE_LO  = 30;
  localparam int MODE_W   = 2;
  localparam logic [MODE_W-1:0] MODE_EXT = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_REQ    = 2'd2,
    ST_GAP    = 2'd3
  } seq_st_e;
endpackage

// File: rtl/thsc_regs.sv
module thsc_regs
  import thsc_pkg::*;
#(
  parameter int DEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [31:0]       wdata,
  output logic              run_o,
  output logic              kill_o,
  output logic              flush_o,
  output logic              ext_o,
  output logic [CH_W-1:0]   chsel_o,
  output logic [OSR_W-1:0]  osr_o,
  output logic              byp_o,
  output logic [DEP_W-1:0]  depth_o
);
  logic              start_q, rst_q, en_q, byp_q;
  logic [CH_W-1:0]   ch_q;
  logic [OSR_W-1:0]  osr_q;
  logic [MODE_W-1:0] mode_q;
  logic [DEP_W-1:0]  dep_q;

  logic              wr0, wr1;
  logic              nx_ext;
  logic [CH_W-1:0]   nx_sel;
  logic              unused_bits;

  assign wr0 = we & ~sel;
  assign wr1 = we & sel;

  // effective source selected by the incoming word
  always_comb begin
    nx_ext = (wdata[MODE_LO +: MODE_W] == MODE_EXT);
    nx_sel = nx_ext ? wdata[CH_LO +: CH_W] : '0;
  end

  assign ext_o   = (mode_q == MODE_EXT);
  assign chsel_o = ext_o ? ch_q : '0;
  assign run_o   = start_q & en_q & ~rst_q;
  assign kill_o  = ~en_q | rst_q;
  assign osr_o   = osr_q;
  assign byp_o   = byp_q;
  assign depth_o = dep_q;

  assign flush_o = wr0 & ((nx_ext != ext_o) | (nx_sel != chsel_o) |
                          ~wdata[B_START] | ~wdata[B_EN] | wdata[B_RST]);

  assign unused_bits = ^{wdata[31:MODE_LO+MODE_W], wdata[MODE_LO-1:OSR_LO+OSR_W],
                         wdata[OSR_LO-1:CH_LO+CH_W], wdata[CH_LO-1:B_BYP+1],
                         wdata[B_BYP-1:B_EN+1], wdata[31:DEP_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      rst_q   <= 1'b0;
      en_q    <= 1'b0;
      byp_q   <= 1'b0;
      ch_q    <= '0;
      osr_q   <= '0;
      mode_q  <= '0;
    end else if (wr0) begin
      start_q <= wdata[B_START];
      rst_q   <= wdata[B_RST];
      en_q    <= wdata[B_EN];
      byp_q   <= wdata[B_BYP];
      ch_q    <= wdata[CH_LO +: CH_W];
      osr_q   <= wdata[OSR_LO +: OSR_W];
      mode_q  <= wdata[MODE_LO +: MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dep_q <= '0;
    else if (wr1) dep_q <= wdata[DEP_W-1:0];
  end
endmodule

// File: rtl/thsc_seq.sv
module thsc_seq
  import thsc_pkg::*;
#(
  parameter int LAT_CYC  = 20,
  parameter int GAP_BASE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             flush,
  input  logic [OSR_W-1:0] osr,
  input  logic             rdy,
  output logic             req_o,
  output logic             take_o,
  output logic             active_o
);
  localparam int GAP_MAX = GAP_BASE << ((1 << OSR_W) - 1);
  localparam int MAXC    = (LAT_CYC > GAP_MAX) ? LAT_CYC : GAP_MAX;
  localparam int CW      = $clog2(MAXC + 1);

  seq_st_e        st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  gap_len;

  assign gap_len  = CW'(GAP_BASE) << osr;
  assign req_o    = (st_q == ST_REQ) & run;
  assign take_o   = req_o & rdy & ~flush;
  assign active_o = (st_q == ST_REQ) | (st_q == ST_GAP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!run) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (flush) begin
      st_d  = ST_SETTLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = ST_SETTLE;
          cnt_d = '0;
        end
        ST_SETTLE: begin
          if (cnt_q == CW'(LAT_CYC - 1)) begin
            st_d  = ST_REQ;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_REQ: begin
          if (rdy) begin
            st_d  = ST_GAP;
            cnt_d = '0;
          end
        end
        ST_GAP: begin
          if (cnt_q == gap_len - 1'b1) begin
            st_d  = ST_REQ;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/thsc_avg.sv
module thsc_avg #(
  parameter int SMP_W = 10,
  parameter int DEP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [SMP_W-1:0] data,
  input  logic             active,
  input  logic             flush,
  input  logic             kill,
  input  logic [DEP_W-1:0] depth,
  input  logic             byp,
  output logic [SMP_W-1:0] result_o,
  output logic             valid_o
);
  localparam int CNT_W = 1 << DEP_W;
  localparam int ACC_W = SMP_W + CNT_W - 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum_c, mean_c;
  logic [CNT_W-1:0] cnt_q, cnt_d, target;
  logic [DEP_W-1:0] nset_q, nset_d, n_live, n_use;
  logic [SMP_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;

  assign n_live = byp ? '0 : depth;
  assign n_use  = (cnt_q == '0) ? n_live : nset_q;
  assign target = CNT_W'(1) << n_use;
  assign sum_c  = acc_q + ACC_W'(data);
  assign mean_c = sum_c >> n_use;

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    nset_d = nset_q;
    res_d  = res_q;
    vld_d  = vld_q;
    if (kill) begin
      acc_d = '0;
      cnt_d = '0;
      res_d = '0;
      vld_d = 1'b0;
    end else if (flush) begin
      acc_d = '0;
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (!active) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (take) begin
      nset_d = n_use;
      if (cnt_q + 1'b1 == target) begin
        res_d = mean_c[SMP_W-1:0];
        vld_d = 1'b1;
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = sum_c;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      nset_q <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      nset_q <= nset_d;
      res_q  <= res_d;
      vld_q  <= vld_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
endmodule

// File: rtl/thermal_sample_ctrl.sv
module thermal_sample_ctrl
  import thsc_pkg::*;
#(
  parameter int SMP_W    = 10,
  parameter int DEP_W    = 3,
  parameter int LAT_CYC  = 20,
  parameter int GAP_BASE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic             cvt_req_o,
  output logic             cvt_ext_o,
  output logic [3:0]       cvt_sel_o,
  input  logic             cvt_rdy_i,
  input  logic [SMP_W-1:0] cvt_data_i,
  output logic [31:0]      status_o
);
  logic             run, kill, flush, byp, take, active, valid;
  logic [OSR_W-1:0] osr;
  logic [DEP_W-1:0] depth;
  logic [SMP_W-1:0] result;

  thsc_regs #(.DEP_W(DEP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .run_o(run), .kill_o(kill), .flush_o(flush), .ext_o(cvt_ext_o),
    .chsel_o(cvt_sel_o), .osr_o(osr), .byp_o(byp), .depth_o(depth)
  );

  thsc_seq #(.LAT_CYC(LAT_CYC), .GAP_BASE(GAP_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .flush(flush), .osr(osr),
    .rdy(cvt_rdy_i), .req_o(cvt_req_o), .take_o(take), .active_o(active)
  );

  thsc_avg #(.SMP_W(SMP_W), .DEP_W(DEP_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .take(take), .data(cvt_data_i),
    .active(active), .flush(flush), .kill(kill), .depth(depth), .byp(byp),
    .result_o(result), .valid_o(valid)
  );

  assign status_o = {{(32-SMP_W-1){1'b0}}, valid, result};
endmodule

// File: rtl/thsc_chk.sv
module thsc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        reg_sel,
  input logic [31:0] reg_wdata,
  input logic        cvt_req_o,
  input logic        cvt_ext_o,
  input logic [3:0]  cvt_sel_o,
  input logic        cvt_rdy_i,
  input logic [31:0] status_o
);
  AST_INT_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cvt_ext_o |-> cvt_sel_o == 4'd0);  // R2

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:11] == '0);  // R4

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[10]) |-> $past(cvt_req_o && cvt_rdy_i));  // R4

  AST_SRC_CHANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel && ((reg_wdata[31:30] == 2'd2) != cvt_ext_o))
    |=> !status_o[10]);  // R7

  AST_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel && !reg_wdata[0]) |=> (!status_o[10] && !cvt_req_o));  // R8

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel && (!reg_wdata[2] || reg_wdata[1]))
    |=> !status_o[10] ##1 (status_o[9:0] == '0 && !cvt_req_o));  // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_req_o && !cvt_rdy_i && !reg_we) |=> cvt_req_o);  // R10

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_req_o && !reg_we) |=> ($stable(cvt_sel_o) && $stable(cvt_ext_o)));  // R10
endmodule

bind thermal_sample_ctrl thsc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .cvt_req_o(cvt_req_o), .cvt_ext_o(cvt_ext_o),
  .cvt_sel_o(cvt_sel_o), .cvt_rdy_i(cvt_rdy_i), .status_o(status_o)
);

// File: tb/thermal_sample_ctrl_tb.sv
module thermal_sample_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT   = 20;
  localparam int GAPB  = 2;
  localparam logic [31:0] F_ST  = 32'h1;
  localparam logic [31:0] F_RS  = 32'h2;
  localparam logic [31:0] F_EN  = 32'h4;
  localparam logic [31:0] F_BYP = 32'h40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        cvt_req_o, cvt_ext_o, cvt_rdy_i = 1'b0;
  logic [3:0]  cvt_sel_o;
  logic [9:0]  cvt_data_i = '0;
  logic [31:0] status_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_sample_ctrl #(.SMP_W(10), .DEP_W(3), .LAT_CYC(LAT), .GAP_BASE(GAPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cvt_req_o(cvt_req_o), .cvt_ext_o(cvt_ext_o),
    .cvt_sel_o(cvt_sel_o), .cvt_rdy_i(cvt_rdy_i), .cvt_data_i(cvt_data_i),
    .status_o(status_o)
  );

  int total = 0, bad = 0, cyc = 0, nres = 0, last_exp = 0;
  int win_sum = 0, win_cnt = 0, win_n = 0, cur_n = 0, k = 0;
  bit stub_en = 1'b0, chk_pend = 1'b0, req_seen = 1'b0;
  string phase = "R4";
  int expq[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw0(int mode, int ch, int osr, logic [31:0] fl);
    return (32'(mode) << 30) | (32'(osr) << 24) | (32'(ch) << 13) | fl;
  endfunction

  function automatic int stub_val(bit e, int s, int kk);
    return (e ? 300 + 40 * s : 100) + ((kk * 7) & 15);
  endfunction

  // scoreboard driver side: collect accepted samples, push expected means
  always @(posedge clk) begin
    cyc++;
    if (rst_n && cvt_req_o && cvt_rdy_i) begin
      if (win_cnt == 0) win_n = cur_n;
      win_sum += int'(cvt_data_i);
      win_cnt++;
      k++;
      if (win_cnt == (1 << win_n)) begin
        expq.push_back(win_sum >> win_n);
        win_sum = 0;
        win_cnt = 0;
        chk_pend = 1'b1;
      end
    end
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // converter stub
  always @(negedge clk) begin
    if (stub_en && cvt_req_o) begin
      cvt_rdy_i  <= 1'b1;
      cvt_data_i <= 10'(stub_val(cvt_ext_o, int'(cvt_sel_o), k));
    end else begin
      cvt_rdy_i <= 1'b0;
    end
  end

  // monitor: pop and compare published results
  always @(negedge clk) begin
    if (cvt_req_o) req_seen = 1'b1;
    if (chk_pend) begin
      int e;
      chk_pend = 1'b0;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        last_exp = e;
        nres++;
        chk(status_o[9:0] == 10'(e) && status_o[10], phase, int'(status_o[10:0]), e + 1024);
      end
    end
  end

  task automatic wr(bit s, logic [31:0] d, bit clr);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    if (clr) begin win_sum = 0; win_cnt = 0; end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pause();
    stub_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_res(int n, string tag);
    int tgt;
    tgt = nres + n;
    for (int i = 0; i < 5000 && nres < tgt; i++) @(negedge clk);
    chk(nres >= tgt, tag, nres, tgt);
  endtask

  task automatic lat_chk(string tag);
    int errs;
    errs = 0;
    for (int i = 0; i < LAT; i++) begin
      if (cvt_req_o || status_o[10]) errs++;
      if (i < LAT - 1) @(negedge clk);
    end
    chk(errs == 0, tag, errs, 0);
    for (int i = 0; i < 2 && !cvt_req_o; i++) @(negedge clk);
    chk(cvt_req_o, tag, int'(cvt_req_o), 1);
  endtask

  task automatic measure(int exp, string tag);
    int t0;
    for (int i = 0; i < 200 && cvt_req_o; i++) @(negedge clk);
    for (int i = 0; i < 200 && !cvt_req_o; i++) @(negedge clk);
    for (int i = 0; i < 200 && cvt_req_o; i++) @(negedge clk);
    for (int i = 0; i < 200 && !cvt_req_o; i++) @(negedge clk);
    t0 = cyc;
    for (int i = 0; i < 200 && cvt_req_o; i++) @(negedge clk);
    for (int i = 0; i < 200 && !cvt_req_o; i++) @(negedge clk);
    chk(cyc - t0 == exp, tag, cyc - t0, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(status_o == 0 && !cvt_req_o, "R1 in reset", int'(status_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(status_o == 0 && !cvt_req_o, "R1 after reset", int'(status_o), 0);

    // internal mode with a stray index, depth 1
    wr(1'b1, 32'd1, 1'b0);
    cur_n = 1;
    stub_en = 1'b1;
    wr(1'b0, cw0(0, 5, 0, F_EN | F_ST), 1'b1);
    chk(!cvt_ext_o && cvt_sel_o == 0, "R2 internal ignores index", int'(cvt_sel_o), 0);
    lat_chk("R3 start latency");
    phase = "R4 depth1 internal";
    wait_res(3, "R4 results");

    // sample spacing
    measure(GAPB + 1, "R6 osr0 interval");
    pause();
    wr(1'b0, cw0(0, 5, 2, F_EN | F_ST), 1'b0);
    stub_en = 1'b1;
    measure((GAPB << 2) + 1, "R6 osr2 interval");

    // depth 2, then switch to external 3 mid-set
    pause();
    wr(1'b1, 32'd2, 1'b0);
    cur_n = 2;
    stub_en = 1'b1;
    phase = "R4 depth2";
    wait_res(1, "R4 depth2 result");
    for (int i = 0; i < 500 && win_cnt != 1; i++) @(negedge clk);
    pause();
    chk(win_cnt != 0 && status_o[10], "R7 partial set before switch", win_cnt, 1);
    wr(1'b0, cw0(2, 3, 0, F_EN | F_ST), 1'b1);
    chk(!status_o[10], "R7 valid drops on switch", int'(status_o[10]), 0);
    chk(cvt_ext_o && cvt_sel_o == 4'd3, "R2 external index", int'(cvt_sel_o), 3);
    stub_en = 1'b1;
    lat_chk("R3 switch latency");
    phase = "R7 fresh set after switch";
    wait_res(2, "R7 results");

    // bypass
    pause();
    wr(1'b0, cw0(2, 3, 0, F_EN | F_ST | F_BYP), 1'b0);
    cur_n = 0;
    stub_en = 1'b1;
    phase = "R5 bypass";
    wait_res(4, "R5 results");

    // stop and restart
    pause();
    wr(1'b0, cw0(2, 3, 0, F_EN | F_BYP), 1'b1);
    chk(!status_o[10], "R8 valid drops on stop", int'(status_o[10]), 0);
    chk(int'(status_o[9:0]) == last_exp, "R8 sample held", int'(status_o[9:0]), last_exp);
    stub_en = 1'b1;
    req_seen = 1'b0;
    repeat (40) @(negedge clk);
    chk(!req_seen, "R8 no requests while stopped", int'(req_seen), 0);
    wr(1'b0, cw0(2, 3, 0, F_EN | F_ST | F_BYP), 1'b1);
    lat_chk("R8 restart latency");
    phase = "R8 after restart";
    wait_res(2, "R8 results");

    // disable, then reset bit
    pause();
    wr(1'b0, cw0(2, 3, 0, F_ST), 1'b1);
    @(negedge clk);
    chk(status_o == 0 && !cvt_req_o, "R9 disable clears", int'(status_o), 0);
    stub_en = 1'b1;
    req_seen = 1'b0;
    repeat (20) @(negedge clk);
    chk(!req_seen, "R9 no requests disabled", int'(req_seen), 0);
    wr(1'b0, cw0(2, 3, 0, F_EN | F_ST | F_RS), 1'b1);
    @(negedge clk);
    req_seen = 1'b0;
    repeat (20) @(negedge clk);
    chk(status_o == 0 && !req_seen, "R9 reset bit holds idle", int'(status_o), 0);
    pause();
    wr(1'b1, 32'd1, 1'b0);
    cur_n = 1;
    wr(1'b0, cw0(0, 0, 0, F_EN | F_ST), 1'b1);
    stub_en = 1'b1;
    phase = "R9 recovery";
    wait_res(1, "R9 recovery result");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule